// File: doc/BRIEF.md
# Banked VRAM Window Mapper

This block sits between the CPU's view of the legacy graphics aperture and a larger linear video memory. The CPU sees a window of either 64 KiB or 128 KiB. The window size follows a mode input. Each CPU offset is turned into a linear VRAM address by adding a bank number times 64 KiB. Reads use a read bank and writes use a write bank. The result is folded into a power-of-two VRAM size. The mapping is live only while a packed-pixel colour mode is selected. In any other mode the block reports no hit and drives a zero address.

Software can load the two bank registers through three routes. The first is a mode-control register, which is decoded differently in the new and old register modes. The second is a graphics source-extension register. The third is a pair of dedicated bank ports, which can also be read back. A control register decides which routes are open. One of its bits opens the dedicated ports. Another bit splits the read bank from the write bank. Register writes come in on one strobed bus, and port reads are combinational.

Top module: `vbm_window_mapper`

## Requirements
- R1: After synchronous active-low reset, both banks, the source-extension register and the control register are zero, so both bank ports read 0xFF.
- R2: A write to the write port (select 3) with control bit 2 set loads the write bank from data bits 4:0. It also loads the read bank unless control bit 0 is set. With control bit 2 clear the write is ignored.
- R3: A write to the read port (select 4) loads the read bank from data bits 4:0 only when control bits 2 and 0 are both set. Otherwise both banks hold.
- R4: With rd_sel_i = 0, rd_data_o is the zero-extended write bank when control bit 2 is set, and 0xFF otherwise. With rd_sel_i = 1, it is the zero-extended read bank when control bits 2 and 0 are both set, and 0xFF otherwise.
- R5: A mode-control write (select 0) in new mode loads the write bank with data bits 3:0 XOR 0b0010, with bank bit 4 zero. It loads the read bank with the same value only when control bit 0 is clear. Control bit 2 is not consulted.
- R6: A mode-control write in old mode loads the banks the same way as R5, but the bank value is data bits 2:1 in place, with all other bank bits zero.
- R7: A source-extension write (select 1) stores the data XOR 0x02 on src_o. When control bit 2 is clear and control bit 0 is set, it also loads the read bank with data bits 4:0 XOR 0b00010.
- R8: While mapping is active, vram_addr_o is the selected bank times 0x10000 plus the offset, modulo 2^VRAM_AW. The write bank is used when cpu_is_wr_i is 1, and the read bank otherwise. The address follows the inputs in the same cycle.
- R9: In new mode only offset bits 15:0 are used, so offset bit 16 has no effect. In old mode all 17 offset bits are used.
- R10: With packed_en_i low, map_hit_o is 0 and vram_addr_o is 0. With packed_en_i high, map_hit_o is 1.
- R11: Select 2 writes the control register (bit 2 opens the ports, bit 0 splits the banks). Selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| new_mode_i | input | 1 | 1 = new register mode with a 64 KiB window, 0 = old mode with a 128 KiB window |
| packed_en_i | input | 1 | A packed-pixel colour mode is selected |
| wr_stb_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register write target: 0 mode-control, 1 source-extension, 2 control, 3 write port, 4 read port |
| wr_data_i | input | 8 | Register write data |
| rd_sel_i | input | 1 | Port read select: 0 write port, 1 read port |
| rd_data_o | output | 8 | Port read data |
| cpu_off_i | input | 17 | CPU offset inside the window |
| cpu_is_wr_i | input | 1 | The current CPU access is a write |
| vram_addr_o | output | 20 | Linear VRAM address |
| map_hit_o | output | 1 | Banked mapping is active |
| wbank_o | output | 5 | Current write bank |
| rbank_o | output | 5 | Current read bank |
| src_o | output | 8 | Source-extension register contents |

## Verification
Any wrong bank value shows up in the very next cycle in two places. It appears on wbank_o or rbank_o, and every address produced for that access direction moves by whole 64 KiB pages. A control register holding the wrong value shows up at once on the port read data, as 0xFF where a bank should appear or the reverse. The same fault shows up one write later, when a port write or source-extension write loads a bank it should have left alone. Offset-masking and wrap errors are combinational, so they show up in the upper address bits in the same cycle as the offset that triggers them.

// File: rtl/vbm_pkg.sv
// Package: shared constants and write-target codes for the banked window mapper.
// Assumes an 8-bit register data bus.
package vbm_pkg;
    typedef enum logic [2:0] {
        SEL_MODE1 = 3'd0,
        SEL_SRC   = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_PORTW = 3'd3,
        SEL_PORTR = 3'd4
    } wsel_e;

    localparam int          CTRL_EN_BIT  = 2;
    localparam int          CTRL_SEP_BIT = 0;
    localparam logic [7:0]  INV_MASK     = 8'h02;
    localparam logic [7:0]  PORT_CLOSED  = 8'hFF;
endpackage

// File: rtl/vbm_bank_regs.sv
// Module: bank, source-extension and control registers with their three load routes.
// Assumes BANK_W >= 4 and BANK_W <= DATA_W. At most one register write per cycle.
module vbm_bank_regs
    import vbm_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_mode_i,
    input  logic              wr_stb_i,
    input  logic [2:0]        wr_sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [BANK_W-1:0] wbank_o,
    output logic [BANK_W-1:0] rbank_o,
    output logic [DATA_W-1:0] src_o,
    output logic [DATA_W-1:0] ctrl_o
);
    localparam logic [BANK_W-1:0] BANK_INV = INV_MASK[BANK_W-1:0];

    logic [BANK_W-1:0] wbank_q, rbank_q, wbank_d, rbank_d;
    logic [DATA_W-1:0] src_q, ctrl_q, src_d, ctrl_d;
    logic [BANK_W-1:0] mode1_val, port_val;
    logic              ports_en, split;

    // Decode the control bits and the bank value that a mode-control write would load.
    always_comb begin
        ports_en  = ctrl_q[CTRL_EN_BIT];
        split     = ctrl_q[CTRL_SEP_BIT];
        port_val  = wr_data_i[BANK_W-1:0];
        mode1_val = '0;
        if (new_mode_i)
            mode1_val[3:0] = wr_data_i[3:0] ^ BANK_INV[3:0];
        else
            mode1_val[2:1] = wr_data_i[2:1];
    end

    // Next-state selection for all four registers from the single write port.
    always_comb begin
        wbank_d = wbank_q;
        rbank_d = rbank_q;
        src_d   = src_q;
        ctrl_d  = ctrl_q;
        if (wr_stb_i) begin
            case (wr_sel_i)
                SEL_MODE1: begin
                    wbank_d = mode1_val;
                    if (!split) rbank_d = mode1_val;
                end
                SEL_SRC: begin
                    src_d = wr_data_i ^ INV_MASK[DATA_W-1:0];
                    if (!ports_en && split) rbank_d = port_val ^ BANK_INV;
                end
                SEL_CTRL: ctrl_d = wr_data_i;
                SEL_PORTW: begin
                    if (ports_en) begin
                        wbank_d = port_val;
                        if (!split) rbank_d = port_val;
                    end
                end
                SEL_PORTR: begin
                    if (ports_en && split) rbank_d = port_val;
                end
                default: ;
            endcase
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbank_q <= '0;
            rbank_q <= '0;
            src_q   <= '0;
            ctrl_q  <= '0;
        end else begin
            wbank_q <= wbank_d;
            rbank_q <= rbank_d;
            src_q   <= src_d;
            ctrl_q  <= ctrl_d;
        end
    end

    assign wbank_o = wbank_q;
    assign rbank_o = rbank_q;
    assign src_o   = src_q;
    assign ctrl_o  = ctrl_q;
endmodule

// File: rtl/vbm_port_read.sv
// Module: combinational read-back of the two dedicated bank ports.
// Assumes BANK_W <= DATA_W. A closed port reads all ones.
module vbm_port_read
    import vbm_pkg::*;
#(
    parameter int BANK_W = 5,
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] ctrl_i,
    input  logic [BANK_W-1:0] wbank_i,
    input  logic [BANK_W-1:0] rbank_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o
);
    // Pick the addressed port and apply its open/closed condition.
    always_comb begin
        rd_data_o = PORT_CLOSED[DATA_W-1:0];
        if (!rd_sel_i) begin
            if (ctrl_i[CTRL_EN_BIT]) rd_data_o = DATA_W'(wbank_i);
        end else begin
            if (ctrl_i[CTRL_EN_BIT] && ctrl_i[CTRL_SEP_BIT]) rd_data_o = DATA_W'(rbank_i);
        end
    end
endmodule

// File: rtl/vbm_addr_gen.sv
// Module: turns a window offset and a bank into a linear VRAM address.
// Assumes the VRAM size is 2^VRAM_AW bytes, so the wrap is a plain truncation.
module vbm_addr_gen #(
    parameter int BANK_W  = 5,
    parameter int OFF_W   = 17,
    parameter int PAGE_W  = 16,
    parameter int VRAM_AW = 20
) (
    input  logic               packed_en_i,
    input  logic               new_mode_i,
    input  logic               is_wr_i,
    input  logic [OFF_W-1:0]   off_i,
    input  logic [BANK_W-1:0]  wbank_i,
    input  logic [BANK_W-1:0]  rbank_i,
    output logic [VRAM_AW-1:0] addr_o,
    output logic               hit_o
);
    localparam int BASE_W = BANK_W + PAGE_W;
    localparam int WIDE_W = (BASE_W > OFF_W) ? BASE_W : OFF_W;
    localparam int SUM_W  = ((WIDE_W + 1) > VRAM_AW) ? (WIDE_W + 1) : VRAM_AW;

    logic [BANK_W-1:0] bank;
    logic [SUM_W-1:0]  base, offx, sum;

    // Choose the bank by access direction and the offset width by window mode.
    always_comb begin
        bank = is_wr_i ? wbank_i : rbank_i;
        base = SUM_W'(bank) << PAGE_W;
        offx = new_mode_i ? SUM_W'(off_i[PAGE_W-1:0]) : SUM_W'(off_i);
        sum  = base + offx;
    end

    // Gate the result by the packed-pixel mode and fold it into the VRAM size.
    always_comb begin
        hit_o  = packed_en_i;
        addr_o = packed_en_i ? sum[VRAM_AW-1:0] : '0;
    end
endmodule

// File: rtl/vbm_window_mapper.sv
// Module: top of the banked VRAM window mapper.
// Assumes one register write per cycle and an external decode of the packed-pixel mode.
module vbm_window_mapper #(
    parameter int BANK_W  = 5,
    parameter int DATA_W  = 8,
    parameter int OFF_W   = 17,
    parameter int PAGE_W  = 16,
    parameter int VRAM_AW = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               new_mode_i,
    input  logic               packed_en_i,
    input  logic               wr_stb_i,
    input  logic [2:0]         wr_sel_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               rd_sel_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [OFF_W-1:0]   cpu_off_i,
    input  logic               cpu_is_wr_i,
    output logic [VRAM_AW-1:0] vram_addr_o,
    output logic               map_hit_o,
    output logic [BANK_W-1:0]  wbank_o,
    output logic [BANK_W-1:0]  rbank_o,
    output logic [DATA_W-1:0]  src_o
);
    logic [DATA_W-1:0] ctrl_q;

    vbm_bank_regs #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_mode_i (new_mode_i),
        .wr_stb_i   (wr_stb_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .wbank_o    (wbank_o),
        .rbank_o    (rbank_o),
        .src_o      (src_o),
        .ctrl_o     (ctrl_q)
    );

    vbm_port_read #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_rd (
        .ctrl_i    (ctrl_q),
        .wbank_i   (wbank_o),
        .rbank_i   (rbank_o),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o)
    );

    vbm_addr_gen #(.BANK_W(BANK_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .VRAM_AW(VRAM_AW)) u_addr (
        .packed_en_i (packed_en_i),
        .new_mode_i  (new_mode_i),
        .is_wr_i     (cpu_is_wr_i),
        .off_i       (cpu_off_i),
        .wbank_i     (wbank_o),
        .rbank_i     (rbank_o),
        .addr_o      (vram_addr_o),
        .hit_o       (map_hit_o)
    );
endmodule

// File: rtl/vbm_window_mapper_chk.sv
// Checker: temporal properties of the window mapper, bound to the top module.
// Assumes VRAM_AW >= PAGE_W.
module vbm_window_mapper_chk
    import vbm_pkg::*;
#(
    parameter int BANK_W  = 5,
    parameter int DATA_W  = 8,
    parameter int OFF_W   = 17,
    parameter int PAGE_W  = 16,
    parameter int VRAM_AW = 20
) (
    input logic               clk,
    input logic               rst_n,
    input logic               new_mode_i,
    input logic               packed_en_i,
    input logic               wr_stb_i,
    input logic [2:0]         wr_sel_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic               rd_sel_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic [OFF_W-1:0]   cpu_off_i,
    input logic [VRAM_AW-1:0] vram_addr_o,
    input logic               map_hit_o,
    input logic [BANK_W-1:0]  wbank_o,
    input logic [BANK_W-1:0]  rbank_o,
    input logic [DATA_W-1:0]  src_o,
    input logic [DATA_W-1:0]  ctrl_q
);
    a_r2_portw_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_sel_i == SEL_PORTW && ctrl_q[CTRL_EN_BIT])
        |=> wbank_o == $past(wr_data_i[BANK_W-1:0]));

    a_r3_portr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_sel_i == SEL_PORTR && !(ctrl_q[CTRL_EN_BIT] && ctrl_q[CTRL_SEP_BIT]))
        |=> ($stable(rbank_o) && $stable(wbank_o)));

    a_r4_portw_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[CTRL_EN_BIT] && !rd_sel_i) |-> rd_data_o == PORT_CLOSED[DATA_W-1:0]);

    a_r6_old_align: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_sel_i == SEL_MODE1 && !new_mode_i)
        |=> (wbank_o[0] == 1'b0 && wbank_o[BANK_W-1:3] == '0));

    a_r7_src_inv: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && wr_sel_i == SEL_SRC)
        |=> src_o == ($past(wr_data_i) ^ INV_MASK[DATA_W-1:0]));

    a_r9_low_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (packed_en_i && new_mode_i) |-> vram_addr_o[PAGE_W-1:0] == cpu_off_i[PAGE_W-1:0]);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !packed_en_i |-> (vram_addr_o == '0 && !map_hit_o));
endmodule

bind vbm_window_mapper vbm_window_mapper_chk #(
    .BANK_W(BANK_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .VRAM_AW(VRAM_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .new_mode_i  (new_mode_i),
    .packed_en_i (packed_en_i),
    .wr_stb_i    (wr_stb_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .rd_sel_i    (rd_sel_i),
    .rd_data_o   (rd_data_o),
    .cpu_off_i   (cpu_off_i),
    .vram_addr_o (vram_addr_o),
    .map_hit_o   (map_hit_o),
    .wbank_o     (wbank_o),
    .rbank_o     (rbank_o),
    .src_o       (src_o),
    .ctrl_q      (ctrl_q)
);

// File: tb/tb_vbm_window_mapper.sv
// Bench: a vector walk over register writes, then directed address, wrap and reset tests.
module tb_vbm_window_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        new_mode_i = 1'b1;
    logic        packed_en_i = 1'b0;
    logic        wr_stb_i = 1'b0;
    logic [2:0]  wr_sel_i = 3'd0;
    logic [7:0]  wr_data_i = 8'h00;
    logic        rd_sel_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic [16:0] cpu_off_i = 17'h0;
    logic        cpu_is_wr_i = 1'b0;
    logic [19:0] vram_addr_o;
    logic        map_hit_o;
    logic [4:0]  wbank_o, rbank_o;
    logic [7:0]  src_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    vbm_window_mapper dut (
        .clk(clk), .rst_n(rst_n), .new_mode_i(new_mode_i), .packed_en_i(packed_en_i),
        .wr_stb_i(wr_stb_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
        .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .cpu_off_i(cpu_off_i),
        .cpu_is_wr_i(cpu_is_wr_i), .vram_addr_o(vram_addr_o), .map_hit_o(map_hit_o),
        .wbank_o(wbank_o), .rbank_o(rbank_o), .src_o(src_o)
    );

    // Fields: sel, data, new_mode, expected wbank, rbank, write-port read, read-port read, src.
    localparam int NVEC = 17;
    localparam logic [45:0] VEC [NVEC] = '{
        {3'd3, 8'h15, 1'b1, 5'h00, 5'h00, 8'hFF, 8'hFF, 8'h00},
        {3'd2, 8'h04, 1'b1, 5'h00, 5'h00, 8'h00, 8'hFF, 8'h00},
        {3'd3, 8'h1A, 1'b1, 5'h1A, 5'h1A, 8'h1A, 8'hFF, 8'h00},
        {3'd4, 8'h05, 1'b1, 5'h1A, 5'h1A, 8'h1A, 8'hFF, 8'h00},
        {3'd2, 8'h05, 1'b1, 5'h1A, 5'h1A, 8'h1A, 8'h1A, 8'h00},
        {3'd3, 8'h03, 1'b1, 5'h03, 5'h1A, 8'h03, 8'h1A, 8'h00},
        {3'd4, 8'h11, 1'b1, 5'h03, 5'h11, 8'h03, 8'h11, 8'h00},
        {3'd0, 8'h0F, 1'b1, 5'h0D, 5'h11, 8'h0D, 8'h11, 8'h00},
        {3'd1, 8'h1F, 1'b1, 5'h0D, 5'h11, 8'h0D, 8'h11, 8'h1D},
        {3'd2, 8'h01, 1'b1, 5'h0D, 5'h11, 8'hFF, 8'hFF, 8'h1D},
        {3'd1, 8'h16, 1'b1, 5'h0D, 5'h14, 8'hFF, 8'hFF, 8'h14},
        {3'd0, 8'hFF, 1'b0, 5'h06, 5'h14, 8'hFF, 8'hFF, 8'h14},
        {3'd2, 8'h00, 1'b0, 5'h06, 5'h14, 8'hFF, 8'hFF, 8'h14},
        {3'd0, 8'hFB, 1'b0, 5'h02, 5'h02, 8'hFF, 8'hFF, 8'h14},
        {3'd0, 8'h35, 1'b1, 5'h07, 5'h07, 8'hFF, 8'hFF, 8'h14},
        {3'd7, 8'hFF, 1'b1, 5'h07, 5'h07, 8'hFF, 8'hFF, 8'h14},
        {3'd1, 8'h00, 1'b1, 5'h07, 5'h07, 8'hFF, 8'hFF, 8'h02}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_stb_i  = 1'b1;
        wr_sel_i  = sel;
        wr_data_i = data;
        @(negedge clk);
        wr_stb_i  = 1'b0;
    endtask

    task automatic check_ports(input logic [7:0] exp_w, input logic [7:0] exp_r);
        rd_sel_i = 1'b0;
        #1 check("R4 write-port read", 32'(rd_data_o), 32'(exp_w));
        rd_sel_i = 1'b1;
        #1 check("R4 read-port read", 32'(rd_data_o), 32'(exp_r));
        rd_sel_i = 1'b0;
    endtask

    task automatic check_addr(input string tag, input logic nm, input logic wr,
                              input logic [16:0] off, input logic [19:0] exp);
        @(negedge clk);
        packed_en_i = 1'b1;
        new_mode_i  = nm;
        cpu_is_wr_i = wr;
        cpu_off_i   = off;
        #1 check(tag, 32'(vram_addr_o), 32'(exp));
    endtask

    initial begin : watchdog
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 wbank", 32'(wbank_o), 32'h0);
        check("R1 rbank", 32'(rbank_o), 32'h0);
        check("R1 src", 32'(src_o), 32'h0);
        check_ports(8'hFF, 8'hFF);

        for (int i = 0; i < NVEC; i++) begin
            new_mode_i = VEC[i][34];
            reg_write(VEC[i][45:43], VEC[i][42:35]);
            case (VEC[i][45:43])
                3'd0: tag = VEC[i][34] ? "R5" : "R6";
                3'd1: tag = "R7";
                3'd2: tag = "R11";
                3'd3: tag = "R2";
                3'd4: tag = "R3";
                default: tag = "R11";
            endcase
            #1;
            check({tag, " wbank"}, 32'(wbank_o), 32'(VEC[i][33:29]));
            check({tag, " rbank"}, 32'(rbank_o), 32'(VEC[i][28:24]));
            check({tag, " src"}, 32'(src_o), 32'(VEC[i][7:0]));
            check_ports(VEC[i][23:16], VEC[i][15:8]);
        end

        // Open and split the ports: write bank 0x03, read bank 0x1F.
        new_mode_i = 1'b1;
        reg_write(3'd2, 8'h05);
        reg_write(3'd3, 8'h03);
        reg_write(3'd4, 8'h1F);
        check_addr("R9 new-mode write masks offset bit 16", 1'b1, 1'b1, 17'h1ABCD, 20'h3ABCD);
        check("R10 hit while packed", 32'(map_hit_o), 32'h1);
        check_addr("R8 new-mode read wraps at VRAM size", 1'b1, 1'b0, 17'h1ABCD, 20'hFABCD);
        check_addr("R8 old-mode read wraps at VRAM size", 1'b0, 1'b0, 17'h1ABCD, 20'h0ABCD);
        check_addr("R9 old-mode write uses 17 bits", 1'b0, 1'b1, 17'h1FFFF, 20'h4FFFF);
        @(negedge clk);
        packed_en_i = 1'b0;
        #1;
        check("R10 idle address", 32'(vram_addr_o), 32'h0);
        check("R10 idle hit", 32'(map_hit_o), 32'h0);

        // R1: reset in mid-run clears all state.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 wbank after rerun reset", 32'(wbank_o), 32'h0);
        check("R1 rbank after rerun reset", 32'(rbank_o), 32'h0);
        check("R1 src after rerun reset", 32'(src_o), 32'h0);
        check_ports(8'hFF, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule